// File: doc/BRIEF.md
# Indirect Memory Access Sequencer

This block executes the indirect-addressing operations of a small 8-bit accumulator machine. There are no pointer registers. A 16-bit pointer sits in data memory at an even operand location. The sequencer fetches that pointer and then uses it for one of four accesses:

- load a data byte into the accumulator;
- store the accumulator to a data byte;
- return the low half of a program-memory word;
- return the high half of a program-memory word.

A stack-relative source can replace the operand location. The pointer is then taken from the byte pair that starts at the current stack pointer, which is the first free location just above the top of the stack.

The instruction decoder issues a request with an opcode, the operand address, the accumulator value and the stack pointer. Every operation takes two busy cycles. The first cycle reads the pointer pair. The second cycle performs the access. A one-cycle done strobe follows, carrying the accumulator writeback. Data memory is seen as a combinational read port that returns the aligned byte pair containing the presented byte address, plus a byte write port. Program memory is a combinational word read port.

Top module: `ind_mem_seq`

## Requirements
- R1: While reset is asserted and after its release, `busy_o`, `done_o`, `err_o`, `acc_we_o` and `dm_we_o` are low until a request is accepted.
- R2: In the first busy cycle, `dm_addr_o` presents the pointer location. The pointer is little-endian: its low byte is at the even location and its high byte at the next one.
- R3: Opcode 2'b00 (load) returns the data byte at the pointer address on `acc_o`, with `acc_we_o` high. The byte comes from bits 7:0 of `dm_rdata_i` when the pointer is even and from bits 15:8 when it is odd.
- R4: Opcode 2'b01 (store) drives `dm_we_o` for exactly the second busy cycle, with `dm_addr_o` at the pointer address and `dm_wdata_o` equal to the accumulator captured at the request. `acc_we_o` stays low.
- R5: Opcode 2'b10 (table low) returns bits 7:0 of the program word at the pointer address.
- R6: Opcode 2'b11 (table high) returns bits PW-1:8 of the program word, zero-extended to 8 bits.
- R7: With `stk_i` high, the pointer location is `sp_i` and `addr_i` is not used.
- R8: Pointer bits above DAW (data accesses) or PAW (program accesses) have no effect on the address.
- R9: An accepted request (`req_i` high while `busy_o` is low at a clock edge) holds `busy_o` high for exactly two cycles. `done_o` is high for the one cycle after them.
- R10: A request raised while `busy_o` is high is not taken. It is accepted at the first edge at which `busy_o` is low, and the earlier operation completes unchanged.
- R11: An odd pointer location sets `err_o` together with `done_o`. No data-memory write occurs, and `acc_we_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Operation request |
| op_i | input | 2 | 00 load, 01 store, 10 table low, 11 table high |
| stk_i | input | 1 | Take the pointer from the stack pointer location |
| addr_i | input | DAW | Operand location of the pointer |
| sp_i | input | DAW | Current stack pointer |
| acc_i | input | 8 | Accumulator value |
| busy_o | output | 1 | Operation in progress |
| dm_addr_o | output | DAW | Data memory byte address |
| dm_rdata_i | input | 16 | Aligned byte pair containing dm_addr_o |
| dm_we_o | output | 1 | Data memory byte write enable |
| dm_wdata_o | output | 8 | Data memory write byte |
| pm_addr_o | output | PAW | Program memory word address |
| pm_rdata_i | input | PW | Program memory word |
| done_o | output | 1 | Operation complete strobe |
| err_o | output | 1 | Misaligned pointer location, valid with done_o |
| acc_we_o | output | 1 | Accumulator writeback enable |
| acc_o | output | 8 | Accumulator writeback value |

## Verification
Two events can fall in the same cycle: the done strobe of one operation, and acceptance of a request that was held off while that operation was busy. The bench provokes this by raising a load request during a store and holding it high. The load reads the address the store writes. The bench checks that the store completes with its done strobe, that the load is accepted only at the edge that ends that done cycle, and that the load returns the byte the store just wrote.

// File: rtl/ims_pkg.sv
package ims_pkg;
  typedef enum logic [1:0] {
    OP_LD  = 2'b00,
    OP_ST  = 2'b01,
    OP_TLO = 2'b10,
    OP_THI = 2'b11
  } ims_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_PTR  = 2'b01,
    ST_ACC  = 2'b10
  } ims_state_e;
endpackage

// File: rtl/ims_ctrl.sv
module ims_ctrl
  import ims_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  output logic       accept_o,
  output ims_state_e state_o,
  output logic       fin_o
);
  ims_state_e state_q;

  assign accept_o = req_i && (state_q == ST_IDLE);
  assign state_o  = state_q;
  assign fin_o    = (state_q == ST_ACC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else begin
      unique case (state_q)
        ST_IDLE: if (accept_o) state_q <= ST_PTR;
        ST_PTR:  state_q <= ST_ACC;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ims_ptr.sv
module ims_ptr
  import ims_pkg::*;
#(
  parameter int DAW = 7,
  parameter int PAW = 11,
  localparam int PTRW = (DAW > PAW) ? DAW : PAW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            accept_i,
  input  ims_state_e      state_i,
  input  logic            stk_i,
  input  logic [DAW-1:0]  addr_i,
  input  logic [DAW-1:0]  sp_i,
  input  logic [15:0]     dm_rdata_i,
  output logic            err_o,
  output logic [PTRW-1:0] ptr_o,
  output logic [DAW-1:0]  dm_addr_o,
  output logic [PAW-1:0]  pm_addr_o
);
  logic [DAW-1:0]  loc_q;
  logic [PTRW-1:0] ptr_q;
  logic            err_q;
  logic [DAW-1:0]  loc_d;

  assign loc_d = stk_i ? sp_i : addr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      loc_q <= '0;
      err_q <= 1'b0;
      ptr_q <= '0;
    end else begin
      if (accept_i) begin
        loc_q <= loc_d;
        err_q <= loc_d[0];
      end
      // upper pointer bits beyond both address widths are dropped here
      if (state_i == ST_PTR) ptr_q <= dm_rdata_i[PTRW-1:0];
    end
  end

  assign err_o     = err_q;
  assign ptr_o     = ptr_q;
  assign dm_addr_o = (state_i == ST_ACC) ? ptr_q[DAW-1:0] : loc_q;
  assign pm_addr_o = ptr_q[PAW-1:0];
endmodule

// File: rtl/ims_access.sv
module ims_access
  import ims_pkg::*;
#(
  parameter int PW = 14,
  localparam int HW = PW - 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic          fin_i,
  input  logic [1:0]    op_i,
  input  logic [7:0]    acc_i,
  input  logic          err_i,
  input  logic          lane_i,
  input  logic [15:0]   dm_rdata_i,
  input  logic [PW-1:0] pm_rdata_i,
  output logic          dm_we_o,
  output logic [7:0]    dm_wdata_o,
  output logic          done_o,
  output logic          err_o,
  output logic          acc_we_o,
  output logic [7:0]    acc_o
);
  ims_op_e    op_q;
  logic [7:0] acc_q;
  logic [7:0] res_d;

  always_comb begin
    res_d = '0;
    unique case (op_q)
      OP_LD:   res_d = lane_i ? dm_rdata_i[15:8] : dm_rdata_i[7:0];
      OP_TLO:  res_d = pm_rdata_i[7:0];
      OP_THI:  res_d[HW-1:0] = pm_rdata_i[PW-1:8];
      default: res_d = '0;
    endcase
  end

  assign dm_we_o    = fin_i && (op_q == OP_ST) && !err_i;
  assign dm_wdata_o = acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q     <= OP_LD;
      acc_q    <= '0;
      done_o   <= 1'b0;
      err_o    <= 1'b0;
      acc_we_o <= 1'b0;
      acc_o    <= '0;
    end else begin
      if (accept_i) begin
        op_q  <= ims_op_e'(op_i);
        acc_q <= acc_i;
      end
      done_o   <= fin_i;
      err_o    <= fin_i && err_i;
      acc_we_o <= fin_i && !err_i && (op_q != OP_ST);
      if (fin_i) acc_o <= err_i ? 8'h00 : res_d;
    end
  end
endmodule

// File: rtl/ind_mem_seq.sv
module ind_mem_seq
  import ims_pkg::*;
#(
  parameter int PW  = 14,
  parameter int DAW = 7,
  parameter int PAW = 11,
  localparam int PTRW = (DAW > PAW) ? DAW : PAW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_i,
  input  logic [1:0]     op_i,
  input  logic           stk_i,
  input  logic [DAW-1:0] addr_i,
  input  logic [DAW-1:0] sp_i,
  input  logic [7:0]     acc_i,
  output logic           busy_o,
  output logic [DAW-1:0] dm_addr_o,
  input  logic [15:0]    dm_rdata_i,
  output logic           dm_we_o,
  output logic [7:0]     dm_wdata_o,
  output logic [PAW-1:0] pm_addr_o,
  input  logic [PW-1:0]  pm_rdata_i,
  output logic           done_o,
  output logic           err_o,
  output logic           acc_we_o,
  output logic [7:0]     acc_o
);
  logic            accept;
  logic            fin;
  logic            err_q;
  logic [PTRW-1:0] ptr;
  ims_state_e      state;

  ims_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .accept_o(accept),
    .state_o (state),
    .fin_o   (fin)
  );

  ims_ptr #(.DAW(DAW), .PAW(PAW)) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .state_i   (state),
    .stk_i     (stk_i),
    .addr_i    (addr_i),
    .sp_i      (sp_i),
    .dm_rdata_i(dm_rdata_i),
    .err_o     (err_q),
    .ptr_o     (ptr),
    .dm_addr_o (dm_addr_o),
    .pm_addr_o (pm_addr_o)
  );

  ims_access #(.PW(PW)) u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .fin_i     (fin),
    .op_i      (op_i),
    .acc_i     (acc_i),
    .err_i     (err_q),
    .lane_i    (ptr[0]),
    .dm_rdata_i(dm_rdata_i),
    .pm_rdata_i(pm_rdata_i),
    .dm_we_o   (dm_we_o),
    .dm_wdata_o(dm_wdata_o),
    .done_o    (done_o),
    .err_o     (err_o),
    .acc_we_o  (acc_we_o),
    .acc_o     (acc_o)
  );

  assign busy_o = (state != ST_IDLE);
endmodule

// File: rtl/ims_chk.sv
module ims_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_o,
  input logic done_o,
  input logic err_o,
  input logic acc_we_o,
  input logic dm_we_o
);
  a_r9_busy_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |=> busy_o);
  a_r9_busy_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |=> !busy_o);
  a_r9_done_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r11_no_write_on_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && err_o |-> !$past(dm_we_o) && !acc_we_o);
  a_r4_write_in_second_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dm_we_o |-> busy_o && $past(busy_o));
  a_r3_writeback_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_we_o |-> done_o);
endmodule

bind ind_mem_seq ims_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .err_o   (err_o),
  .acc_we_o(acc_we_o),
  .dm_we_o (dm_we_o)
);

// File: tb/ind_mem_seq_tb_top.sv
`timescale 1ns/1ps
module ind_mem_seq_tb_top;
  localparam int PW = 14, DAW = 7, PAW = 11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, stk = 1'b0;
  logic [1:0] op = '0;
  logic [DAW-1:0] addr = '0, sp = '0;
  logic [7:0] acc = '0;
  logic busy, dm_we, done, err, acc_we;
  logic [DAW-1:0] dm_addr;
  logic [15:0] dm_rdata;
  logic [7:0] dm_wdata, acc_o;
  logic [PAW-1:0] pm_addr;
  logic [PW-1:0] pm_rdata;
  logic [7:0] mem [128];
  logic [7:0] snap [128];
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  function automatic logic [PW-1:0] pmf(input logic [PAW-1:0] a);
    return PW'(int'(a) * 37 + 5);
  endfunction

  assign dm_rdata = {mem[{dm_addr[6:1], 1'b1}], mem[{dm_addr[6:1], 1'b0}]};
  assign pm_rdata = pmf(pm_addr);
  always @(posedge clk) if (dm_we) mem[dm_addr] <= dm_wdata;

  ind_mem_seq #(.PW(PW), .DAW(DAW), .PAW(PAW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .op_i(op), .stk_i(stk),
    .addr_i(addr), .sp_i(sp), .acc_i(acc), .busy_o(busy),
    .dm_addr_o(dm_addr), .dm_rdata_i(dm_rdata), .dm_we_o(dm_we),
    .dm_wdata_o(dm_wdata), .pm_addr_o(pm_addr), .pm_rdata_i(pm_rdata),
    .done_o(done), .err_o(err), .acc_we_o(acc_we), .acc_o(acc_o)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic string op_tag(input logic [1:0] o);
    case (o)
      2'b00: return "R3";
      2'b01: return "R4";
      2'b10: return "R5";
      default: return "R6";
    endcase
  endfunction

  // {op, stk, loc, ptr, acc}
  localparam int NV = 12;
  localparam logic [33:0] VEC [NV] = '{
    {2'd0, 1'b0, 7'h10, 16'h0040, 8'h00},
    {2'd0, 1'b0, 7'h12, 16'h0051, 8'h00},
    {2'd1, 1'b0, 7'h14, 16'h0060, 8'hA5},
    {2'd1, 1'b0, 7'h16, 16'h0063, 8'h3C},
    {2'd2, 1'b0, 7'h18, 16'h0123, 8'h00},
    {2'd3, 1'b0, 7'h1A, 16'h07FF, 8'h00},
    {2'd3, 1'b0, 7'h1C, 16'h0000, 8'h00},
    {2'd0, 1'b1, 7'h30, 16'h0045, 8'h00},
    {2'd1, 1'b1, 7'h32, 16'h0066, 8'h5A},
    {2'd2, 1'b1, 7'h34, 16'h0400, 8'h00},
    {2'd0, 1'b0, 7'h1E, 16'hFF05, 8'h00},
    {2'd2, 1'b0, 7'h20, 16'hF812, 8'h00}
  };

  task automatic do_op(input logic [1:0] o, input logic s, input logic [6:0] loc,
                       input logic [15:0] p, input logic [7:0] a, input string xtag);
    logic err_exp;
    logic [7:0] exp_v;
    logic [PW-1:0] w;
    err_exp = loc[0];
    if (!err_exp) begin
      mem[loc] = p[7:0];
      mem[loc | 7'h01] = p[15:8];
    end
    w = pmf(p[PAW-1:0]);
    case (o)
      2'b00: exp_v = mem[p[6:0]];
      2'b10: exp_v = w[7:0];
      2'b11: exp_v = 8'(w[PW-1:8]);
      default: exp_v = 8'h00;
    endcase
    for (int i = 0; i < 128; i++) snap[i] = mem[i];
    @(negedge clk);
    req = 1'b1; op = o; stk = s; acc = a;
    addr = s ? (loc ^ 7'h08) : loc;
    sp   = s ? loc : (loc ^ 7'h08);
    @(posedge clk); #1;
    req = 1'b0;
    chk(busy, "R9", "busy after accept", 32'(busy), 1);
    @(negedge clk);
    chk(dm_addr == loc, s ? "R7" : "R2", {xtag, " pointer location"}, 32'(dm_addr), 32'(loc));
    chk(!dm_we, "R2", "no write in pointer cycle", 32'(dm_we), 0);
    @(negedge clk);
    chk(busy, "R9", "busy second cycle", 32'(busy), 1);
    chk(dm_we == (o == 2'b01 && !err_exp), err_exp ? "R11" : "R4", {xtag, " write enable"},
        32'(dm_we), 32'(o == 2'b01 && !err_exp));
    if (o == 2'b01 && !err_exp)
      chk(dm_addr == p[6:0], "R4", {xtag, " write address"}, 32'(dm_addr), 32'(p[6:0]));
    @(negedge clk);
    chk(done && !busy, "R9", "done after two busy cycles", 32'({done, busy}), 32'h2);
    chk(err == err_exp, "R11", "error flag", 32'(err), 32'(err_exp));
    chk(acc_we == (o != 2'b01 && !err_exp), err_exp ? "R11" : op_tag(o), "writeback enable",
        32'(acc_we), 32'(o != 2'b01 && !err_exp));
    if (!err_exp && o != 2'b01)
      chk(acc_o == exp_v, op_tag(o), {xtag, " result"}, 32'(acc_o), 32'(exp_v));
    if (!err_exp && o == 2'b01)
      chk(mem[p[6:0]] == a, "R4", {xtag, " stored byte"}, 32'(mem[p[6:0]]), 32'(a));
    if (err_exp) begin
      int diff = 0;
      for (int i = 0; i < 128; i++) if (mem[i] != snap[i]) diff++;
      chk(diff == 0, "R11", "memory untouched", 32'(diff), 0);
    end
    @(negedge clk);
    chk(!done, "R9", "done one cycle", 32'(done), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    chk({busy, done, err, acc_we, dm_we} == 5'b0, "R1", "outputs in reset",
        32'({busy, done, err, acc_we, dm_we}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({busy, done, err, acc_we, dm_we} == 5'b0, "R1", "outputs after reset",
        32'({busy, done, err, acc_we, dm_we}), 0);

    for (int v = 0; v < NV; v++) begin
      logic [33:0] e;
      e = VEC[v];
      do_op(e[33:32], e[31], e[30:24], e[23:8], e[7:0],
            (v >= 10) ? "R8 upper bits" : $sformatf("vec%0d", v));
    end

    // R11: odd operand location, store and stack-relative load
    do_op(2'b01, 1'b0, 7'h21, 16'h0000, 8'hEE, "R11 odd m");
    do_op(2'b00, 1'b1, 7'h37, 16'h0000, 8'h00, "R11 odd sp");

    // R10: load raised during a store to the same address and held
    mem[7'h24] = 8'h70; mem[7'h25] = 8'h00;
    mem[7'h26] = 8'h70; mem[7'h27] = 8'h12;
    @(negedge clk);
    req = 1'b1; op = 2'b01; stk = 1'b0; addr = 7'h24; acc = 8'h99;
    @(posedge clk); #1;
    op = 2'b00; addr = 7'h26; acc = 8'h00;
    @(negedge clk);
    chk(busy && dm_addr == 7'h24, "R10", "first op pointer cycle", 32'(dm_addr), 32'h24);
    @(negedge clk);
    chk(dm_we && dm_addr == 7'h70, "R10", "first op store kept", 32'(dm_addr), 32'h70);
    @(negedge clk);
    chk(done && !busy && !acc_we, "R10", "store done while load held",
        32'({done, busy, acc_we}), 32'h4);
    @(posedge clk); #1;
    chk(busy, "R10", "held load accepted when idle", 32'(busy), 1);
    req = 1'b0;
    @(negedge clk);
    chk(dm_addr == 7'h26, "R10", "held load pointer location", 32'(dm_addr), 32'h26);
    @(negedge clk);
    @(negedge clk);
    chk(done && acc_we && acc_o == 8'h99, "R10", "held load reads stored byte",
        32'(acc_o), 32'h99);

    @(negedge clk);
    chk({busy, done, dm_we} == 3'b0, "R9", "idle afterwards", 32'({busy, done, dm_we}), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule